// File: doc/BRIEF.md
# Cascadable Serial Static Segment Driver

This block drives a direct-drive liquid crystal panel with a parameterised number of segments (40 by default). A host sends display data one bit at a time on a serial data input, together with a serial shift clock. Each falling edge of the shift clock moves the data one stage along an internal shift register. The last stage drives a serial data output, so several of these blocks can be chained by connecting each output to the next block's data input and sharing the shift clock, strobe and frame lines.

A level-sensitive strobe copies the shift register into a bank of display latches. The latches follow the register for as long as the strobe is high and hold the value once it falls. Every segment output is its latched bit combined by XOR with an external low-rate frame signal, which gives the panel AC drive. Any output whose latch holds 0 follows the frame signal in phase and can therefore serve as the backplane. A blank input forces every output low without disturbing the latches.

All pins are sampled on a fast system clock. The shift clock's falling edge is detected by comparing it with its value one system-clock cycle earlier. An asynchronous active-low reset clears the shift register and the latches.

Top module: `static_seg_driver`

## Requirements
- R1: After reset the shift register and latches hold 0, so `sdo` is 0 and, with `blank` low, every `seg` bit equals `frame`.
- R2: The shift register moves only on a falling edge of `sclk` (high at one system-clock edge, low at the next). A rising edge or a steady `sclk` leaves the contents unchanged.
- R3: After a falling edge, `sdi` occupies index 0 (`seg[0]`) and every other bit moves one index up. After N shifts, the first bit shifted in sits at index N-1.
- R4: `sdo` is the last stage, N-1. After N falling edges `sdo` shows the first bit shifted in, and each later falling edge presents the next bit. This delays the serial stream by N shift periods for cascading.
- R5: While `strobe` is high, the latches take the shift register contents on every system clock, so a shift made during the strobe reaches the outputs.
- R6: While `strobe` is low, the latches keep their value and shifting does not change `seg`.
- R7: With `blank` low, each `seg` bit equals its latched bit XOR `frame`. A latched 0 follows `frame`, and a latched 1 gives its inverse.
- R8: With `blank` high, every `seg` bit is 0 whatever `frame` is. When `blank` returns low, the previous display comes back unchanged.
- R9: `seg` follows changes of `frame` even when `sclk` and `strobe` are idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample every pin |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial shift clock; data moves on its falling edge |
| sdi | input | 1 | Serial data input |
| strobe | input | 1 | Level-sensitive latch enable |
| blank | input | 1 | Forces all segment outputs low when high |
| frame | input | 1 | External frame signal for AC drive |
| sdo | output | 1 | Serial data output (last shift stage) |
| seg | output | N | Segment outputs, index 0 holds the newest bit |

## Verification
The assertions assume that `sclk`, `sdi`, `strobe`, `blank` and `frame` are already synchronous to `clk` and that each `sclk` level lasts at least one system-clock cycle, so every falling edge is seen once. They also assume that the strobe rises only after a shift has finished and falls before the next falling edge of `sclk`. The stimulus changes every input just after a falling edge of `clk` and holds each `sclk` level for at least one full system cycle. It raises and lowers the strobe between shift operations, except in the one test that shifts deliberately while the strobe is high to show the latches are transparent.

// File: rtl/static_seg_driver.sv
module static_seg_driver #(
  parameter int N = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk,
  input  logic         sdi,
  input  logic         strobe,
  input  logic         blank,
  input  logic         frame,
  output logic         sdo,
  output logic [N-1:0] seg
);

  logic         sclk_q;
  logic         sclk_fall;
  logic [N-1:0] shreg;
  logic [N-1:0] lat;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk;

  assign sclk_fall = sclk_q & ~sclk;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         shreg <= '0;
    else if (sclk_fall) shreg <= {shreg[N-2:0], sdi};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      lat <= '0;
    else if (strobe) lat <= shreg;

  assign sdo = shreg[N-1];
  assign seg = blank ? '0 : (lat ^ {N{frame}});

  a_r2_shift_only_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !(sclk_q && !sclk) |=> $stable(shreg));

  a_r3_new_bit_at_low_end: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_q && !sclk) |=> shreg[0] == $past(sdi));

  a_r4_sdo_from_prev_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_q && !sclk) |=> sdo == $past(shreg[N-2]));

  a_r5_transparent: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> lat == $past(shreg));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(lat));

  a_r7_frame_inverts: assert property (@(posedge clk) disable iff (!rst_n)
    (!blank && $past(!blank) && !$stable(frame) && $stable(lat)) |-> seg == ~$past(seg));

  a_r8_blank_low: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> seg == '0);

endmodule

// File: tb/test_static_seg_driver.sv
module test_static_seg_driver;
  localparam int N = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdi = 1'b0, strobe = 1'b0, blank = 1'b0, frame = 1'b0;
  logic sdo;
  logic [N-1:0] seg;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  static_seg_driver #(.N(N)) i_static_seg_driver (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .strobe(strobe),
    .blank(blank), .frame(frame), .sdo(sdo), .seg(seg)
  );

  // {pattern, frame, blank}
  localparam logic [N+1:0] VEC [6] = '{
    {40'hA5_5A_0F_F0_C3, 1'b0, 1'b0},
    {40'hA5_5A_0F_F0_C3, 1'b1, 1'b0},
    {40'h80_00_00_00_01, 1'b0, 1'b0},
    {40'hFF_FF_FF_FF_FF, 1'b1, 1'b0},
    {40'h12_34_56_78_9A, 1'b1, 1'b1},
    {40'h00_00_00_00_00, 1'b1, 1'b0}
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shift_bit(logic b);
    sdi = b; sclk = 1'b1; tick(); tick();
    sclk = 1'b0; tick();
  endtask

  task automatic load(logic [N-1:0] p);
    for (int i = N-1; i >= 0; i--) shift_bit(p[i]);
  endtask

  task automatic pulse_strobe();
    strobe = 1'b1; tick(); tick();
    strobe = 1'b0; tick();
  endtask

  function automatic logic [N-1:0] model(logic [N-1:0] p, logic f, logic b);
    return b ? '0 : (p ^ {N{f}});
  endfunction

  initial begin
    #800000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] a, b;
    tick(); tick();
    // R1: reset state
    check("R1 seg", seg, '0);
    check("R1 sdo", {{(N-1){1'b0}}, sdo}, '0);
    frame = 1'b1; tick();
    check("R1 frame during reset", seg, {N{1'b1}});
    frame = 1'b0;
    rst_n = 1'b1; tick(); tick();
    check("R1 after release", seg, '0);

    // R3 R7 R8: table walk
    for (int v = 0; v < 6; v++) begin
      load(VEC[v][N+1:2]);
      pulse_strobe();
      frame = VEC[v][1]; blank = VEC[v][0]; tick();
      check("R3/R7/R8 table", seg, model(VEC[v][N+1:2], VEC[v][1], VEC[v][0]));
      frame = 1'b0; blank = 1'b0; tick();
    end

    // R3: single bit ordering
    a = 40'h0;
    load(a); shift_bit(1'b1); pulse_strobe();
    check("R3 newest at index 0", seg, 40'h1);
    for (int i = 0; i < N-1; i++) shift_bit(1'b0);
    pulse_strobe();
    check("R3 first bit at top index", seg, 40'h80_00_00_00_00);

    // R4: serial output delay
    a = 40'hC6_3A_91_5E_27;
    b = 40'h35_CA_0F_71_B8;
    load(a);
    check("R4 sdo after N shifts", {{(N-1){1'b0}}, sdo}, {{(N-1){1'b0}}, a[N-1]});
    begin
      int bad = 0;
      for (int k = 1; k < N; k++) begin
        shift_bit(b[N-k]);
        if (sdo !== a[N-1-k]) bad++;
      end
      check("R4 cascade stream mismatches", bad, 0);
    end

    // R2: rising edge and steady high do not shift
    load(a); pulse_strobe();
    sdi = ~a[0]; sclk = 1'b1;
    for (int i = 0; i < 5; i++) begin sdi = ~sdi; tick(); end
    pulse_strobe();
    check("R2 no shift on rise", seg, a);
    sclk = 1'b0; tick();

    // R6: strobe low, shifting leaves display
    load(a); pulse_strobe();
    load(b);
    check("R6 hold while strobe low", seg, a);

    // R5: transparent while strobe high
    strobe = 1'b1; tick(); tick();
    check("R5 follows register", seg, b);
    shift_bit(1'b1); tick();
    check("R5 shift seen during strobe", seg, {b[N-2:0], 1'b1});
    strobe = 1'b0; tick();

    // R8: blank keeps latches
    a = {b[N-2:0], 1'b1};
    blank = 1'b1; tick();
    check("R8 blanked", seg, '0);
    frame = 1'b1; tick();
    check("R8 blanked with frame high", seg, '0);
    load(40'h0);
    blank = 1'b0; tick();
    check("R8 display restored", seg, ~a);

    // R9: frame toggles with no data activity
    frame = 1'b0; tick();
    check("R9 frame low", seg, a);
    frame = 1'b1; tick();
    check("R9 frame high", seg, ~a);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule